// File: doc/BRIEF.md
# Data-Strobe Character Link Receiver

This block sits on the receive side of a serial link that carries two wires, a data line and a strobe line, and no clock line. Exactly one of the two wires changes for each bit sent, so the exclusive-OR of the pair toggles once per bit. The receiver brings both wires into the system clock domain. It treats every toggle of that exclusive-OR, in either direction, as the arrival of one new data bit. It then assembles the bits into link characters.

A character opens with a parity bit and a type flag. After them come either eight payload bits, making a data byte, or two payload bits, making a control code. The block checks odd parity across character boundaries and merges an escape code with a following flow-control token into a NULL. Each kind of character is reported as a one-cycle strobe on its own output. The block also reports parity errors, misuse of the escape code, the first character after reset, and loss of the incoming bit stream. Buffering and credit accounting belong to the surrounding link logic. For each flow-control token, the receiver only pulses an indication.

Top module: `ds_char_rx`

## Requirements
- R1: Every change of the synchronised D XOR S value, rising or falling, captures the synchronised D value as the next received bit.
- R2: The second bit of a character (the type flag) sets its length: flag 0 is followed by 8 payload bits, and flag 1 is followed by 2 payload bits. The next character starts directly after the last payload bit.
- R3: A data character produces a one-cycle `data_valid` with `data_byte`. The first payload bit received is bit 0 of the byte.
- R4: A control character's code is {second payload bit, first payload bit}. 2'b00 is a flow-control token and pulses `fct_pulse`. 2'b10 is a normal end of packet and pulses `eop_valid` with `eop_exc`=0. 2'b01 is an exceptional end of packet and pulses `eop_valid` with `eop_exc`=1. 2'b11 is an escape and produces no pulse by itself.
- R5: An escape followed by a flow-control token pulses `null_pulse` once, and neither `fct_pulse` nor any other character strobe.
- R6: An escape followed by a data character, an end of packet or another escape pulses `esc_err`. That following character is not reported on its own strobe.
- R7: The parity bit of a character, its flag and the payload of the previous character must hold an odd number of ones. If they do not, `parity_err` pulses for one cycle after that character's flag bit. The character is still decoded.
- R8: Parity is not checked on the first character after reset.
- R9: `first_char` pulses exactly once after reset, when the first complete character arrives.
- R10: Once a bit has arrived, `disconnect` goes high if no further bit arrives within `DISC_CYCLES` clock cycles. It stays high until reset. Gaps shorter than the limit leave it low.
- R11: Before the first bit after reset, the disconnect timer does not run, however long the line stays quiet.
- R12: While reset is held and directly after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| d_line | input | 1 | Incoming data wire (asynchronous) |
| s_line | input | 1 | Incoming strobe wire (asynchronous) |
| data_valid | output | 1 | One-cycle strobe for a received data byte |
| data_byte | output | DATA_W | Received data byte |
| eop_valid | output | 1 | One-cycle strobe for an end-of-packet marker |
| eop_exc | output | 1 | With `eop_valid`: 1 for exceptional, 0 for normal |
| fct_pulse | output | 1 | One-cycle strobe per flow-control token |
| null_pulse | output | 1 | One-cycle strobe per NULL (escape plus flow-control token) |
| esc_err | output | 1 | Escape followed by a character other than a flow-control token |
| parity_err | output | 1 | One-cycle strobe on an odd-parity failure |
| first_char | output | 1 | One-cycle strobe on the first character after reset |
| disconnect | output | 1 | Sticky flag: the bit stream stopped |

## Verification
Random streams mix data bytes, both end-of-packet kinds, flow-control tokens, NULLs and stray escapes. This catches a receiver that miscounts the short control length, because every character after that point would decode as garbage, and a receiver that reports the token inside a NULL as a lone flow-control token. Parity is deliberately corrupted on scattered characters. A receiver that checks against the wrong character's payload would then flag the wrong places. A second reset with a corrupted first character shows whether the unchecked first character is honoured. On the timer side, a long quiet period before any traffic exposes a timer that runs before it is armed. A 30-cycle gap inside a character exposes one that is too short. A final silence must raise the flag and keep it raised.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 2;

  // Control code as {second payload bit, first payload bit}
  typedef enum logic [1:0] {
    CC_FCT     = 2'b00,
    CC_EOP_EXC = 2'b01,
    CC_EOP_OK  = 2'b10,
    CC_ESC     = 2'b11
  } ctrl_code_e;
endpackage

// File: rtl/ds_rx_bitsync.sv
module ds_rx_bitsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_line,
  input  logic s_line,
  output logic bit_stb,
  output logic bit_val
);
  logic [STAGES-1:0] d_pipe, s_pipe;
  logic d_now, s_now, d_prev, s_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_pipe <= '0;
      s_pipe <= '0;
      d_prev <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      d_pipe <= {d_pipe[STAGES-2:0], d_line};
      s_pipe <= {s_pipe[STAGES-2:0], s_line};
      d_prev <= d_now;
      s_prev <= s_now;
    end
  end

  assign d_now   = d_pipe[STAGES-1];
  assign s_now   = s_pipe[STAGES-1];
  assign bit_stb = (d_now ^ s_now) != (d_prev ^ s_prev);
  assign bit_val = d_now;

  // R1: a bit is lost if both wires move inside one sample period
  one_line_moves_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({d_now ^ d_prev, s_now ^ s_prev}) <= 1);
endmodule

// File: rtl/ds_rx_framer.sv
module ds_rx_framer
  import ds_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              data_vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              eop_vld_o,
  output logic              eop_exc_o,
  output logic              fct_o,
  output logic              null_o,
  output logic              esc_err_o,
  output logic              par_err_o,
  output logic              first_o
);
  localparam int DATA_LAST = 1 + DATA_W;
  localparam int CTRL_LAST = 1 + CTRL_W;
  localparam int CNT_W     = $clog2(DATA_LAST + 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sr, sr_next;
  logic              is_ctrl, par_bit, cur_par, prev_par;
  logic              have_prev, esc_pend, seen_char, char_done;
  ctrl_code_e        code;

  assign sr_next   = {bit_val, sr[DATA_W-1:1]};
  assign code      = ctrl_code_e'(sr_next[DATA_W-1 -: CTRL_W]);
  assign char_done = is_ctrl ? (cnt == CNT_W'(CTRL_LAST))
                             : (cnt == CNT_W'(DATA_LAST));

  always_ff @(posedge clk) begin
    data_vld_o <= 1'b0;
    eop_vld_o  <= 1'b0;
    fct_o      <= 1'b0;
    null_o     <= 1'b0;
    esc_err_o  <= 1'b0;
    par_err_o  <= 1'b0;
    first_o    <= 1'b0;
    if (rst) begin
      cnt       <= '0;
      sr        <= '0;
      is_ctrl   <= 1'b0;
      par_bit   <= 1'b0;
      cur_par   <= 1'b0;
      prev_par  <= 1'b0;
      have_prev <= 1'b0;
      esc_pend  <= 1'b0;
      seen_char <= 1'b0;
      data_o    <= '0;
      eop_exc_o <= 1'b0;
    end else if (bit_stb) begin
      if (cnt == '0) begin
        par_bit <= bit_val;
        cnt     <= CNT_W'(1);
      end else if (cnt == CNT_W'(1)) begin
        is_ctrl <= bit_val;
        cur_par <= 1'b0;
        if (have_prev && !(prev_par ^ par_bit ^ bit_val))
          par_err_o <= 1'b1;
        cnt <= CNT_W'(2);
      end else begin
        sr      <= sr_next;
        cur_par <= cur_par ^ bit_val;
        if (char_done) begin
          cnt       <= '0;
          prev_par  <= cur_par ^ bit_val;
          have_prev <= 1'b1;
          seen_char <= 1'b1;
          if (!seen_char) first_o <= 1'b1;
          if (!is_ctrl) begin
            esc_pend <= 1'b0;
            if (esc_pend) esc_err_o <= 1'b1;
            else begin
              data_vld_o <= 1'b1;
              data_o     <= sr_next;
            end
          end else begin
            case (code)
              CC_FCT: begin
                esc_pend <= 1'b0;
                if (esc_pend) null_o <= 1'b1;
                else          fct_o  <= 1'b1;
              end
              CC_EOP_OK, CC_EOP_EXC: begin
                esc_pend <= 1'b0;
                if (esc_pend) esc_err_o <= 1'b1;
                else begin
                  eop_vld_o <= 1'b1;
                  eop_exc_o <= (code == CC_EOP_EXC);
                end
              end
              default: begin
                if (esc_pend) begin
                  esc_err_o <= 1'b1;
                  esc_pend  <= 1'b0;
                end else begin
                  esc_pend <= 1'b1;
                end
              end
            endcase
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: the bit counter never passes the end of a data character
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DATA_LAST));

  // R4
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({data_vld_o, eop_vld_o, fct_o, null_o, esc_err_o}));

  // R5
  null_after_esc_chk: assert property (@(posedge clk) disable iff (rst)
    null_o |-> $past(esc_pend));

  // R8
  no_first_parity_chk: assert property (@(posedge clk) disable iff (rst)
    par_err_o |-> $past(have_prev));
endmodule

// File: rtl/ds_rx_linkwatch.sv
module ds_rx_linkwatch #(
  parameter int LIMIT = 43
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  output logic disc_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] quiet;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet  <= '0;
      armed  <= 1'b0;
      disc_o <= 1'b0;
    end else if (bit_stb) begin
      armed <= 1'b1;
      quiet <= '0;
    end else if (armed && !disc_o) begin
      if (quiet == CW'(LIMIT - 1)) disc_o <= 1'b1;
      else                         quiet  <= quiet + 1'b1;
    end
  end

  // R10
  disc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    disc_o |=> disc_o);

  // R11
  disc_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !disc_o);
endmodule

// File: rtl/ds_char_rx.sv
module ds_char_rx
  import ds_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DISC_CYCLES = 43
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_line,
  input  logic              s_line,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_byte,
  output logic              eop_valid,
  output logic              eop_exc,
  output logic              fct_pulse,
  output logic              null_pulse,
  output logic              esc_err,
  output logic              parity_err,
  output logic              first_char,
  output logic              disconnect
);
  logic bit_stb, bit_val;

  ds_rx_bitsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_line(d_line), .s_line(s_line),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  ds_rx_framer u_frame (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .data_vld_o(data_valid), .data_o(data_byte),
    .eop_vld_o(eop_valid), .eop_exc_o(eop_exc),
    .fct_o(fct_pulse), .null_o(null_pulse), .esc_err_o(esc_err),
    .par_err_o(parity_err), .first_o(first_char)
  );

  ds_rx_linkwatch #(.LIMIT(DISC_CYCLES)) u_watch (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .disc_o(disconnect)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(data_valid | eop_valid | fct_pulse | null_pulse |
                     esc_err | parity_err | first_char | disconnect));
endmodule

// File: tb/ds_char_rx_test.sv
module ds_char_rx_test;
  localparam int CLK_PERIOD = 20;
  localparam int DISC       = 43;
  localparam int BIT_CYC    = 4;
  localparam int EV_DATA = 1, EV_EOK = 2, EV_EEX = 3, EV_FCT = 4,
                 EV_NULL = 5, EV_ESCERR = 6, EV_PAR = 7, EV_FIRST = 8;

  logic clk = 1'b0, rst = 1'b1, d_ln = 1'b0, s_ln = 1'b0;
  logic [7:0] data_byte;
  logic data_valid, eop_valid, eop_exc, fct_pulse, null_pulse;
  logic esc_err, parity_err, first_char, disconnect;

  int checks = 0, fails = 0;
  int exp_q[$], got_q[$];
  logic ppar = 1'b0, have_prev = 1'b0, first_pend = 1'b1, esc_pend = 1'b0;
  bit   mon_on = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds_char_rx #(.DISC_CYCLES(DISC)) uut (
    .clk(clk), .rst(rst), .d_line(d_ln), .s_line(s_ln),
    .data_valid(data_valid), .data_byte(data_byte), .eop_valid(eop_valid),
    .eop_exc(eop_exc), .fct_pulse(fct_pulse), .null_pulse(null_pulse),
    .esc_err(esc_err), .parity_err(parity_err), .first_char(first_char),
    .disconnect(disconnect)
  );

  always @(negedge clk) if (mon_on && !rst) begin
    if (first_char) got_q.push_back(EV_FIRST * 256);
    if (parity_err) got_q.push_back(EV_PAR * 256);
    if (data_valid) got_q.push_back(EV_DATA * 256 + int'(data_byte));
    if (eop_valid)  got_q.push_back((eop_exc ? EV_EEX : EV_EOK) * 256);
    if (fct_pulse)  got_q.push_back(EV_FCT * 256);
    if (null_pulse) got_q.push_back(EV_NULL * 256);
    if (esc_err)    got_q.push_back(EV_ESCERR * 256);
  end

  function automatic string tag_of(int ev);
    case (ev / 256)
      EV_DATA:   return "R3";
      EV_EOK, EV_EEX, EV_FCT: return "R4";
      EV_NULL:   return "R5";
      EV_ESCERR: return "R6";
      EV_PAR:    return "R7";
      default:   return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: data-strobe encoding, one wire moves per bit
  task automatic send_bit(input logic b, input int gap);
    repeat (gap) @(negedge clk);
    if (b == d_ln) s_ln = ~s_ln;
    else           d_ln = b;
  endtask

  task automatic send_char(input bit ctrl, input logic [7:0] pl, input bit bad);
    int n = ctrl ? 2 : 8;
    logic px = 1'b0;
    for (int i = 0; i < n; i++) px ^= pl[i];
    send_bit(1'b1 ^ ppar ^ ctrl ^ bad, BIT_CYC);
    send_bit(ctrl, BIT_CYC);
    if (bad && have_prev) exp_q.push_back(EV_PAR * 256);
    for (int i = 0; i < n; i++) send_bit(pl[i], BIT_CYC);
    ppar = px;
    have_prev = 1'b1;
    if (first_pend) begin exp_q.push_back(EV_FIRST * 256); first_pend = 1'b0; end
    if (!ctrl) begin
      exp_q.push_back(esc_pend ? EV_ESCERR * 256 : EV_DATA * 256 + int'(pl));
      esc_pend = 1'b0;
    end else begin
      case (pl[1:0])
        2'b00: exp_q.push_back(esc_pend ? EV_NULL * 256 : EV_FCT * 256);
        2'b10: exp_q.push_back(esc_pend ? EV_ESCERR * 256 : EV_EOK * 256);
        2'b01: exp_q.push_back(esc_pend ? EV_ESCERR * 256 : EV_EEX * 256);
        default: if (esc_pend) exp_q.push_back(EV_ESCERR * 256);
      endcase
      esc_pend = (pl[1:0] == 2'b11) ? !esc_pend : 1'b0;
    end
  endtask

  task automatic compare_events();
    repeat (10) @(negedge clk);
    check(got_q.size() == exp_q.size(), "R1 R2 event count",
          got_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      int g = (i < got_q.size()) ? got_q[i] : -1;
      check(g == exp_q[i], tag_of(exp_q[i]), g, exp_q[i]);
    end
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic do_reset();
    d_ln = 1'b0; s_ln = 1'b0; rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    ppar = 1'b0; have_prev = 1'b0; first_pend = 1'b1; esc_pend = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_v = $urandom(32'd1355);
    int par_in_p2 = 0;
    do_reset();
    // R12
    check({data_valid, eop_valid, fct_pulse, null_pulse, esc_err, parity_err,
           first_char, disconnect} == 8'h00, "R12 reset outputs", 1, 0);
    repeat (100) @(negedge clk);
    // R11
    check(disconnect == 1'b0, "R11 idle before first bit", disconnect, 0);

    // directed: NULL first, data, escape misuse
    send_char(1'b1, 8'h03, 1'b0); send_char(1'b1, 8'h00, 1'b0);
    send_char(1'b0, 8'hA5, 1'b0);
    send_char(1'b1, 8'h03, 1'b0); send_char(1'b0, 8'h3C, 1'b0);
    send_char(1'b1, 8'h03, 1'b0); send_char(1'b1, 8'h03, 1'b0);
    send_char(1'b1, 8'h03, 1'b0); send_char(1'b1, 8'h02, 1'b0);
    send_char(1'b1, 8'h01, 1'b0); send_char(1'b1, 8'h00, 1'b0);
    send_char(1'b0, 8'h00, 1'b1); send_char(1'b0, 8'hFF, 1'b0);
    // R10: 30-cycle gap inside a character stays below the limit
    send_bit(1'b1 ^ ppar, BIT_CYC);
    send_bit(1'b0, BIT_CYC);
    send_bit(1'b0, 30);
    check(disconnect == 1'b0, "R10 short gap", disconnect, 0);
    for (int i = 1; i < 8; i++) send_bit(i[0], BIT_CYC);
    ppar = 1'b0;
    exp_q.push_back(EV_DATA * 256 + 8'hAA);
    compare_events();

    // random mix
    for (int k = 0; k < 60; k++) begin
      int r = $urandom % 10;
      bit bad = ($urandom % 9) == 0;
      case (r)
        0, 1, 2, 3: send_char(1'b0, 8'($urandom), bad);
        4: send_char(1'b1, 8'h02, bad);
        5: send_char(1'b1, 8'h01, bad);
        6: send_char(1'b1, 8'h00, bad);
        7: begin send_char(1'b1, 8'h03, bad); send_char(1'b1, 8'h00, 1'b0); end
        default: send_char(1'b1, 8'h03, bad);
      endcase
    end
    compare_events();

    // R10: silence raises and holds the flag
    repeat (20) @(negedge clk);
    check(disconnect == 1'b0, "R10 before limit", disconnect, 0);
    repeat (60) @(negedge clk);
    check(disconnect == 1'b1, "R10 after limit", disconnect, 1);
    repeat (100) @(negedge clk);
    check(disconnect == 1'b1, "R10 sticky", disconnect, 1);

    // R8: corrupted first character after a new reset
    do_reset();
    check(disconnect == 1'b0, "R12 disconnect cleared", disconnect, 0);
    send_char(1'b0, 8'h5A, 1'b1);
    send_char(1'b1, 8'h00, 1'b0);
    send_char(1'b0, 8'h81, 1'b1);
    repeat (10) @(negedge clk);
    foreach (got_q[i]) if (got_q[i] == EV_PAR * 256) par_in_p2++;
    check(par_in_p2 == 1, "R8 first character unchecked", par_in_p2, 1);
    compare_events();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule